// File: doc/BRIEF.md
# Averaged-Energy Packet Detector with Medium-Idle Flag

This block watches a stream of received signal strength samples, one 10-bit unsigned value per strobed cycle, and keeps a moving sum over the most recent 2^N samples. N is set by software in the range 0 up to a parameterised limit. The sum shifted right by N gives the average. That average, not any single raw sample, is compared against a programmed energy threshold. The packet-present output rises only once the average has stayed strictly above the threshold for a programmed run of consecutive samples.

The block also drives a medium-idle flag that a MAC uses to time its inter-frame spacing. The flag rises once the average has stayed strictly below the threshold for a programmed run of samples. It is forced low at once, in the same cycle, whenever the local transmitter or receiver reports that it is active, whatever the signal strength says.

Four write-only configuration words set the behaviour: threshold, minimum duration, idle length and control. The control word carries the averaging exponent and a self-clearing soft-reset bit. The soft reset empties the sample history, the accumulator and both run counters.

Top module: `rssi_pkt_detect`

## Requirements
- R1: The average is floor(S / 2^N), where S is the sum of the last 2^N accepted samples and samples older than that window have no effect. After a clear, missing samples count as zero.
- R2: With minimum duration M (word 1, all CNT_W bits), `pkt_detect` goes high on the clock edge that accepts the (M+1)-th consecutive sample whose average is strictly greater than the threshold. With M = 0 it follows the comparison with one register delay.
- R3: On the edge that accepts a sample whose average is less than or equal to the threshold, `pkt_detect` falls and the persistence count restarts from zero. An average equal to the threshold is not above it.
- R4: On cycles with `rssi_valid` low, neither the counters nor `pkt_detect` change, whatever `rssi_in` carries.
- R5: With idle length L (word 2), `medium_idle` goes high on the edge that accepts the (L+1)-th consecutive sample whose average is strictly below the threshold. It falls on an accepted sample whose average is at or above the threshold.
- R6: `medium_idle` is low in every cycle in which `tx_active` or `rx_active` is high. This takes effect combinationally, in the same cycle, with no clock edge.
- R7: A write to word 3 with bit 4 set, or a write that changes the averaging exponent, clears the history, the accumulator, both counters and both flags on that edge. A sample presented on the same edge is dropped.
- R8: Word addresses are 0 for the threshold (bits 9:0, upper bits ignored), 1 for the minimum duration, 2 for the idle length and 3 for control (bits 2:0 exponent N, bit 4 soft reset, not stored).
- R9: After reset, both outputs are low, the threshold is all ones (1023), the minimum duration and idle length are 0, and N is 0.
- R10: An exponent written above MAX_LOG2 (4 by default) is clamped to MAX_LOG2, giving a window of 16 samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rssi_in | input | RSSI_W | Unsigned signal strength sample |
| rssi_valid | input | 1 | Sample strobe; counters advance only when high |
| tx_active | input | 1 | Local transmitter busy |
| rx_active | input | 1 | Local receiver busy |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | CNT_W | Configuration write data |
| pkt_detect | output | 1 | Packet present on the medium |
| medium_idle | output | 1 | Medium idle long enough for inter-frame spacing |

## Verification
Single-sample patterns with N = 0 at, just above and just below the threshold show whether the comparison is strict and whether equality counts as above. Bursts of equal strong samples under a nonzero minimum duration, broken by one weak sample, show whether the persistence count, its reset and the off-by-one of the first assertion are right. A lone strong sample followed by zeros with N = 2 shows the exact window length: detection must last four samples and end on the fifth. Samples written with an out-of-range exponent, a soft reset that lands on the same edge as a sample, and busy pulses without a clock edge show the clamp, the clear priority and the combinational override.

// File: rtl/rssi_pd_pkg.sv
package rssi_pd_pkg;

   typedef enum logic [1:0] {
      REG_THRESH  = 2'd0,
      REG_MINDUR  = 2'd1,
      REG_IDLELEN = 2'd2,
      REG_CTRL    = 2'd3
   } reg_sel_e;

   localparam int CTRL_L2_LSB   = 0;
   localparam int CTRL_L2_W     = 3;
   localparam int CTRL_SRST_BIT = 4;

endpackage

// File: rtl/rssi_pd_regs.sv
module rssi_pd_regs
   import rssi_pd_pkg::*;
#(
   parameter int RSSI_W   = 10,
   parameter int MAX_LOG2 = 4,
   parameter int CNT_W    = 16,
   parameter int L2_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CNT_W-1:0]  cfg_wdata,
   output logic [RSSI_W-1:0] thresh,
   output logic [CNT_W-1:0]  min_dur,
   output logic [CNT_W-1:0]  idle_len,
   output logic [L2_W-1:0]   log2n,
   output logic              clear
);

   logic [RSSI_W-1:0]    thresh_q;
   logic [CNT_W-1:0]     min_q;
   logic [CNT_W-1:0]     idle_q;
   logic [L2_W-1:0]      l2_q;
   logic [CTRL_L2_W-1:0] wr_field;
   logic [L2_W-1:0]      wr_l2;
   logic                 ctrl_hit;

   assign wr_field = cfg_wdata[CTRL_L2_LSB +: CTRL_L2_W];
   // out-of-range exponent saturates at the deepest supported window
   assign wr_l2    = (wr_field > CTRL_L2_W'(MAX_LOG2)) ? L2_W'(MAX_LOG2)
                                                       : L2_W'(wr_field);
   assign ctrl_hit = cfg_we && (reg_sel_e'(cfg_addr) == REG_CTRL);
   assign clear    = ctrl_hit && (cfg_wdata[CTRL_SRST_BIT] || (wr_l2 != l2_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thresh_q <= '1;
         min_q    <= '0;
         idle_q   <= '0;
         l2_q     <= '0;
      end else if (cfg_we) begin
         unique case (reg_sel_e'(cfg_addr))
            REG_THRESH:  thresh_q <= cfg_wdata[RSSI_W-1:0];
            REG_MINDUR:  min_q    <= cfg_wdata;
            REG_IDLELEN: idle_q   <= cfg_wdata;
            REG_CTRL:    l2_q     <= wr_l2;
            default:     ;
         endcase
      end
   end

   assign thresh   = thresh_q;
   assign min_dur  = min_q;
   assign idle_len = idle_q;
   assign log2n    = l2_q;

endmodule

// File: rtl/rssi_pd_avg.sv
module rssi_pd_avg #(
   parameter int RSSI_W   = 10,
   parameter int MAX_LOG2 = 4,
   parameter int L2_W     = 3,
   parameter int SUM_W    = RSSI_W + MAX_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              valid,
   input  logic [RSSI_W-1:0] sample,
   input  logic [L2_W-1:0]   log2n,
   output logic [SUM_W-1:0]  avg_next
);

   localparam int DEPTH  = 1 << MAX_LOG2;
   localparam int IDX_W  = MAX_LOG2;
   localparam int WLEN_W = MAX_LOG2 + 1;

   logic [RSSI_W-1:0] tap [DEPTH];
   logic [WLEN_W-1:0] win_len;
   logic [IDX_W-1:0]  tap_sel;
   logic [SUM_W-1:0]  sum_q;
   logic [SUM_W-1:0]  sum_next;

   // history chain, newest sample in stage 0
   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic [RSSI_W-1:0] d;
      logic [RSSI_W-1:0] q;
      if (i == 0) begin : g_head
         assign d = sample;
      end else begin : g_body
         assign d = tap[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= '0;
         else if (clear) q <= '0;
         else if (valid) q <= d;
      end
      assign tap[i] = q;
   end

   // the sample that leaves the window is the oldest one inside it
   assign win_len  = WLEN_W'(1) << log2n;
   assign tap_sel  = win_len[IDX_W-1:0] - IDX_W'(1);
   assign sum_next = sum_q + SUM_W'(sample) - SUM_W'(tap[tap_sel]);
   assign avg_next = sum_next >> log2n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_q <= '0;
      else if (clear) sum_q <= '0;
      else if (valid) sum_q <= sum_next;
   end

endmodule

// File: rtl/rssi_pd_runlen.sv
module rssi_pd_runlen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             hit,
   input  logic [CNT_W-1:0] limit,
   output logic             flag
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt;
   logic             flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         flag_q <= 1'b0;
      end else if (clear) begin
         cnt    <= '0;
         flag_q <= 1'b0;
      end else if (step) begin
         if (hit) begin
            // cnt holds the number of earlier qualifying samples in the run
            flag_q <= (cnt >= limit);
            if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
         end else begin
            cnt    <= '0;
            flag_q <= 1'b0;
         end
      end
   end

   assign flag = flag_q;

endmodule

// File: rtl/rssi_pkt_detect.sv
module rssi_pkt_detect
   import rssi_pd_pkg::*;
#(
   parameter int RSSI_W   = 10,
   parameter int MAX_LOG2 = 4,
   parameter int CNT_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RSSI_W-1:0] rssi_in,
   input  logic              rssi_valid,
   input  logic              tx_active,
   input  logic              rx_active,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CNT_W-1:0]  cfg_wdata,
   output logic              pkt_detect,
   output logic              medium_idle
);

   localparam int L2_W  = $clog2(MAX_LOG2 + 1);
   localparam int SUM_W = RSSI_W + MAX_LOG2;

   if (RSSI_W < 2) begin : g_bad_rssi_w
      $error("RSSI_W must be at least 2");
   end
   if (MAX_LOG2 < 1 || MAX_LOG2 > 7) begin : g_bad_log2
      $error("MAX_LOG2 must lie in 1..7");
   end
   if (CNT_W < RSSI_W || CNT_W <= CTRL_SRST_BIT) begin : g_bad_cnt_w
      $error("CNT_W too narrow for the configuration words");
   end

   logic [RSSI_W-1:0] thresh;
   logic [CNT_W-1:0]  min_dur;
   logic [CNT_W-1:0]  idle_len;
   logic [L2_W-1:0]   log2n;
   logic              clear;
   logic [SUM_W-1:0]  avg_next;
   logic              above;
   logic              below;
   logic              idle_flag;

   rssi_pd_regs #(
      .RSSI_W(RSSI_W), .MAX_LOG2(MAX_LOG2), .CNT_W(CNT_W), .L2_W(L2_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .thresh(thresh), .min_dur(min_dur), .idle_len(idle_len),
      .log2n(log2n), .clear(clear)
   );

   rssi_pd_avg #(
      .RSSI_W(RSSI_W), .MAX_LOG2(MAX_LOG2), .L2_W(L2_W), .SUM_W(SUM_W)
   ) i_avg (
      .clk(clk), .rst_n(rst_n), .clear(clear), .valid(rssi_valid),
      .sample(rssi_in), .log2n(log2n), .avg_next(avg_next)
   );

   assign above = avg_next > SUM_W'(thresh);
   assign below = avg_next < SUM_W'(thresh);

   rssi_pd_runlen #(.CNT_W(CNT_W)) i_det_run (
      .clk(clk), .rst_n(rst_n), .clear(clear), .step(rssi_valid),
      .hit(above), .limit(min_dur), .flag(pkt_detect)
   );

   rssi_pd_runlen #(.CNT_W(CNT_W)) i_idle_run (
      .clk(clk), .rst_n(rst_n), .clear(clear), .step(rssi_valid),
      .hit(below), .limit(idle_len), .flag(idle_flag)
   );

   // local activity means the medium is busy regardless of energy
   assign medium_idle = idle_flag & ~tx_active & ~rx_active;

endmodule

// File: rtl/rssi_pd_checker.sv
module rssi_pd_checker
   import rssi_pd_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rssi_valid,
   input logic             tx_active,
   input logic             rx_active,
   input logic             cfg_we,
   input logic [1:0]       cfg_addr,
   input logic [CNT_W-1:0] cfg_wdata,
   input logic             pkt_detect,
   input logic             medium_idle
);

   p_hold_no_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rssi_valid && !cfg_we) |=> $stable(pkt_detect));

   p_busy_forces_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active || rx_active) |-> !medium_idle);

   p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && reg_sel_e'(cfg_addr) == REG_CTRL && cfg_wdata[CTRL_SRST_BIT])
      |=> (!pkt_detect && !medium_idle));

   p_rise_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_detect) |-> $past(rssi_valid));

   p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_detect && medium_idle));

endmodule

bind rssi_pkt_detect rssi_pd_checker #(.CNT_W(CNT_W)) i_checker (
   .clk(clk), .rst_n(rst_n), .rssi_valid(rssi_valid),
   .tx_active(tx_active), .rx_active(rx_active),
   .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .pkt_detect(pkt_detect), .medium_idle(medium_idle)
);

// File: tb/test_rssi_pkt_detect.sv
module test_rssi_pkt_detect;

   localparam int CLK_PERIOD = 10;
   localparam int RSSI_W     = 10;
   localparam int CNT_W      = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [RSSI_W-1:0] rssi_in;
   logic              rssi_valid;
   logic              tx_active;
   logic              rx_active;
   logic              cfg_we;
   logic [1:0]        cfg_addr;
   logic [CNT_W-1:0]  cfg_wdata;
   logic              pkt_detect;
   logic              medium_idle;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // bench model state, built from the requirements
   int m_hist [16];
   int m_n    = 0;
   int m_thr  = 1023;
   int m_min  = 0;
   int m_idle = 0;
   int m_rc   = 0;
   int m_ic   = 0;
   bit m_det  = 1'b0;
   bit m_idl  = 1'b0;

   rssi_pkt_detect #(.RSSI_W(RSSI_W), .MAX_LOG2(4), .CNT_W(CNT_W)) i_rssi_pkt_detect (
      .clk(clk), .rst_n(rst_n), .rssi_in(rssi_in), .rssi_valid(rssi_valid),
      .tx_active(tx_active), .rx_active(rx_active),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .pkt_detect(pkt_detect), .medium_idle(medium_idle)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%0b expected=%0b", tag, got, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 16; i++) m_hist[i] = 0;
      m_rc = 0; m_ic = 0; m_det = 1'b0; m_idl = 1'b0;
   endtask

   task automatic model_step(input int v);
      int sum;
      int avg;
      for (int i = 15; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = v;
      sum = 0;
      for (int i = 0; i < (1 << m_n); i++) sum += m_hist[i];
      avg = sum >> m_n;
      if (avg > m_thr) begin
         m_det = (m_rc >= m_min);
         if (m_rc < 65535) m_rc++;
      end else begin
         m_rc = 0; m_det = 1'b0;
      end
      if (avg < m_thr) begin
         m_idl = (m_ic >= m_idle);
         if (m_ic < 65535) m_ic++;
      end else begin
         m_ic = 0; m_idl = 1'b0;
      end
   endtask

   task automatic model_ctrl(input int data);
      int nn;
      nn = data & 7;
      if (nn > 4) nn = 4;
      if (((data >> 4) & 1) == 1 || nn != m_n) model_clear();
      m_n = nn;
   endtask

   task automatic check_model(input string tag);
      check({tag, " detect"}, pkt_detect, m_det);
      check({tag, " idle"}, medium_idle, m_idl && !tx_active && !rx_active);
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input int addr, input int data);
      rssi_valid = 1'b0;
      cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = CNT_W'(data);
      @(negedge clk);
      cfg_we = 1'b0;
      case (addr)
         0: m_thr  = data & 1023;
         1: m_min  = data;
         2: m_idle = data;
         default: model_ctrl(data);
      endcase
   endtask

   task automatic push(input int v);
      rssi_in = RSSI_W'(v); rssi_valid = 1'b1;
      @(negedge clk);
      model_step(v);
   endtask

   task automatic t_reset();
      check("R9 reset detect", pkt_detect, 1'b0);
      check("R9 reset idle", medium_idle, 1'b0);
      push(1023);
      check("R9 default threshold 1023 not exceeded", pkt_detect, 1'b0);
      check("R9 default threshold 1023 not below", medium_idle, 1'b0);
      push(500);
      check("R9 default idle length 0", medium_idle, 1'b1);
      check_model("R9");
   endtask

   task automatic t_compare();
      wr(3, 16'h0010);
      wr(0, 16'hFC64);   // R8: upper bits dropped, threshold 100
      wr(1, 0);
      push(150); check("R2 min0 above", pkt_detect, 1'b1);
      push(100); check("R3 equal not above", pkt_detect, 1'b0);
      push(101); check("R8 threshold low bits only", pkt_detect, 1'b1);
      push(99);  check("R3 below clears", pkt_detect, 1'b0);
      check_model("R3");
   endtask

   task automatic t_persist();
      wr(1, 3);
      push(200); check("R2 run1", pkt_detect, 1'b0);
      push(200); check("R2 run2", pkt_detect, 1'b0);
      push(200); check("R2 run3", pkt_detect, 1'b0);
      push(200); check("R2 run4 asserts", pkt_detect, 1'b1);
      push(200); check("R2 stays", pkt_detect, 1'b1);
      push(50);  check("R3 drop", pkt_detect, 1'b0);
      push(200); check("R3 count restarted", pkt_detect, 1'b0);
      check_model("R2");
   endtask

   task automatic t_window();
      wr(1, 0);
      wr(3, 2);          // exponent change clears, window 4
      push(404); check("R1 avg 101", pkt_detect, 1'b1);
      for (int i = 0; i < 3; i++) begin
         push(0); check("R1 inside window", pkt_detect, 1'b1);
      end
      push(0); check("R1 sample left window", pkt_detect, 1'b0);
      check_model("R1");
   endtask

   task automatic t_hold();
      push(404); check("R4 setup", pkt_detect, 1'b1);
      rssi_valid = 1'b0; rssi_in = '0;
      repeat (5) @(negedge clk);
      check("R4 hold without strobe", pkt_detect, 1'b1);
      check_model("R4");
   endtask

   task automatic t_idle();
      wr(3, 16'h0010);
      wr(2, 2);
      push(10); check("R5 run1", medium_idle, 1'b0);
      push(10); check("R5 run2", medium_idle, 1'b0);
      push(10); check("R5 run3 asserts", medium_idle, 1'b1);
      push(100); check("R5 equal drops", medium_idle, 1'b0);
      check_model("R5");
   endtask

   task automatic t_busy();
      push(10); push(10); push(10);
      check("R6 idle before busy", medium_idle, 1'b1);
      rssi_valid = 1'b0;
      tx_active = 1'b1; #1;
      check("R6 tx forces low", medium_idle, 1'b0);
      tx_active = 1'b0; #1;
      check("R6 tx released", medium_idle, 1'b1);
      rx_active = 1'b1; #1;
      check("R6 rx forces low", medium_idle, 1'b0);
      rx_active = 1'b0;
      @(negedge clk);
      check_model("R6");
   endtask

   task automatic t_soft();
      wr(3, 2);
      push(404); check("R7 setup", pkt_detect, 1'b1);
      rssi_in = RSSI_W'(1000); rssi_valid = 1'b1;
      cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = CNT_W'(16'h0012);
      @(negedge clk);
      cfg_we = 1'b0; rssi_valid = 1'b0;
      model_clear();
      check("R7 clear wins over sample", pkt_detect, 1'b0);
      check("R7 idle cleared", medium_idle, 1'b0);
      push(0); check("R7 history emptied", pkt_detect, 1'b0);
      push(404); check("R7 sum emptied", pkt_detect, 1'b1);
      check_model("R7");
   endtask

   task automatic t_clamp();
      wr(3, 7);          // clamps to 4, window 16
      push(1023); check("R10 avg 63", pkt_detect, 1'b0);
      push(1023); check("R10 avg 127", pkt_detect, 1'b1);
      check_model("R10");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rssi_in = '0; rssi_valid = 1'b0;
      tx_active = 1'b0; rx_active = 1'b0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_compare();
      t_persist();
      t_window();
      t_hold();
      t_idle();
      t_busy();
      t_soft();
      t_clamp();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule